// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every memory access, whether the access may proceed under a small table of protection regions. Each table entry holds a configuration byte and an address register, and both are loaded through a one-cycle register-write port. An access presents its byte address, its size in bytes, its kind (read, write or execute) and the privilege level of the requester. The block answers with a single allow bit in the same cycle.

Each entry names its region in one of three ways. The first is a range that reaches from the previous entry's address up to its own. The second is a fixed 4-byte word. The third is a naturally aligned power-of-two block, whose size is encoded by the run of ones at the low end of the address register. The entry with the lowest index that touches the access decides the outcome. It grants the access only when the whole access lies inside its region. A lock bit freezes an entry and makes its permissions apply to machine mode as well.

Top module: `pmp_checker`

## Requirements
- R1: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 range-from-previous, 2 four-byte word, 3 power-of-two block), bit 7 lock. Reset clears every configuration byte and address register. Address register bit k stands for physical address bit k+2.
- R2: In power-of-two mode, with k trailing ones in the address register, the region is 2^(k+3) bytes long. Its base is the register value with its low k+1 bits cleared, shifted left by 2. The last byte of the region is inside it.
- R3: In range mode, entry i covers bytes from (register of entry i-1)<<2 up to, but not including, (own register)<<2. Entry 0 uses 0 as its lower bound. The range is empty when the upper bound is not above the lower bound.
- R4: In four-byte mode, the entry covers the 4 bytes starting at (register)<<2.
- R5: An entry in off mode never matches, yet it keeps its index, and its address register still serves as the lower bound for the entry above it.
- R6: When several entries touch an access, only the lowest-numbered one decides.
- R7: An access covers bytes addr through addr+size-1 (size 1 to 8). If the deciding entry holds only one of those two ends, the access is denied at every privilege level.
- R8: Access kind 0 (read), 1 (write) and 2 (execute) is allowed by a matching entry only if that entry's bit 0, 1 or 2 is set, respectively. Privilege codes 0 (user) and 1 (supervisor) always obey the entry bits.
- R9: Privilege code 3 (machine) is allowed when no entry matches, and also by a matching entry whose lock bit is clear. Lower privileges are denied when no entry matches.
- R10: Writes to the configuration byte or the address register of a locked entry are ignored. The address register of the entry just below a locked range-mode entry also ignores writes. Only reset clears a lock.
- R11: A write to an address register keeps write-data bits 53:0 and discards every higher bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel_addr | input | 1 | 1 writes the address register, 0 writes the configuration byte |
| wr_idx | input | IDX_W | Entry index of the write |
| wr_data | input | WDATA_W | Write data (bits 7:0 for configuration) |
| acc_addr | input | PA_W | Byte address of the access |
| acc_size | input | SIZE_W | Access size in bytes, 1 to 8 |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| acc_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| allow | output | 1 | 1 when the access is permitted |

## Verification
Some rules hold on every cycle, and the bound checker tests them there. At most one entry decides. The deciding entry is the lowest-numbered one touched. A partial overlap always denies. An access that no entry touches follows the privilege default. Locked configuration bytes and address registers never change. The bench scenarios cover the points a property cannot show. These include the exact region edges for each decoding mode, the inclusive end of a power-of-two block and the empty range. They also show that an off entry keeps its index and that upper write-data bits are dropped. Finally, they confirm that writes blocked by a lock leave the allow result unchanged at addresses the write would have moved.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam int CFG_R       = 0;
  localparam int CFG_W       = 1;
  localparam int CFG_X       = 2;
  localparam int CFG_MODE_LO = 3;
  localparam int CFG_MODE_HI = 4;
  localparam int CFG_LOCK    = 7;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_W        = 56,
  parameter int WDATA_W     = 64,
  parameter int IDX_W       = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                wr_sel_addr,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [WDATA_W-1:0]                  wr_data,
  output logic [NUM_ENTRIES-1:0][7:0]         cfg_q,
  output logic [NUM_ENTRIES-1:0][PA_W-3:0]    addr_q
);
  localparam int AW = PA_W - 2;

  // bits above the address field are dropped on write (R11)
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wr_data[WDATA_W-1:AW];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [7:0]    cfg_r;
    logic [AW-1:0] addr_r;
    logic          hit_idx;
    logic          cfg_locked;
    logic          addr_locked;

    assign hit_idx    = wr_en && (wr_idx == IDX_W'(i));
    assign cfg_locked = cfg_r[CFG_LOCK];

    if (i < NUM_ENTRIES - 1) begin : g_upper
      // a locked range entry above protects this entry's address (R10)
      assign addr_locked = cfg_locked ||
        (cfg_q[i+1][CFG_LOCK] &&
         (amode_e'(cfg_q[i+1][CFG_MODE_HI:CFG_MODE_LO]) == AM_TOR));
    end else begin : g_top
      assign addr_locked = cfg_locked;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_r  <= '0;
        addr_r <= '0;
      end else begin
        if (hit_idx && !wr_sel_addr && !cfg_locked) cfg_r <= wr_data[7:0];
        if (hit_idx &&  wr_sel_addr && !addr_locked) addr_r <= wr_data[AW-1:0];
      end
    end

    assign cfg_q[i]  = cfg_r;
    assign addr_q[i] = addr_r;
  end
endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
#(
  parameter int PA_W = 56
) (
  input  logic [1:0]      mode,
  input  logic [PA_W-3:0] own_reg,
  input  logic [PA_W-3:0] prev_reg,
  input  logic [PA_W:0]   first_b,
  input  logic [PA_W:0]   last_b,
  output logic            first_in,
  output logic            last_in
);
  // byte mask of a power-of-two block: trailing ones plus the next bit,
  // widened by the two implicit low address bits (R2)
  function automatic logic [PA_W-1:0] napot_span(input logic [PA_W-3:0] r);
    logic [PA_W-3:0] nxt;
    nxt = r + (PA_W-2)'(1);
    return {r ^ nxt, 2'b11};
  endfunction

  logic [PA_W-1:0] base_b, lo, hi;
  logic            valid;

  always_comb begin
    base_b = {own_reg, 2'b00};
    lo     = '0;
    hi     = '0;
    valid  = 1'b0;
    case (amode_e'(mode))
      AM_TOR: begin
        lo    = {prev_reg, 2'b00};
        hi    = base_b - PA_W'(1);
        valid = base_b > lo;
      end
      AM_NA4: begin
        lo    = base_b;
        hi    = base_b | PA_W'(3);
        valid = 1'b1;
      end
      AM_NAPOT: begin
        lo    = base_b & ~napot_span(own_reg);
        hi    = base_b |  napot_span(own_reg);
        valid = 1'b1;
      end
      default: ;
    endcase
  end

  // both bounds inclusive
  assign first_in = valid && (first_b >= {1'b0, lo}) && (first_b <= {1'b0, hi});
  assign last_in  = valid && (last_b  >= {1'b0, lo}) && (last_b  <= {1'b0, hi});
endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] req,
  output logic [NUM_ENTRIES-1:0] grant,
  output logic                   any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_W        = 56,
  parameter int SIZE_W      = 4,
  parameter int WDATA_W     = 64,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel_addr,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic [PA_W-1:0]    acc_addr,
  input  logic [SIZE_W-1:0]  acc_size,
  input  logic [1:0]         acc_type,
  input  logic [1:0]         acc_priv,
  output logic               allow
);
  function automatic logic perm_ok(input logic [2:0] perm, input logic [1:0] kind);
    case (kind)
      ACC_READ:  return perm[CFG_R];
      ACC_WRITE: return perm[CFG_W];
      ACC_EXEC:  return perm[CFG_X];
      default:   return 1'b0;
    endcase
  endfunction

  logic [NUM_ENTRIES-1:0][7:0]      cfg_q;
  logic [NUM_ENTRIES-1:0][PA_W-3:0] addr_q;
  logic [NUM_ENTRIES-1:0]           first_vec, last_vec, hit_vec, grant_vec;
  logic                             any_hit, full_hit, partial_hit;
  logic [PA_W:0]                    first_b, last_b;
  logic [2:0]                       sel_perm;
  logic                             sel_lock;
  logic                             unused_cfg_rsvd;

  pmp_csr_file #(
    .NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W), .WDATA_W(WDATA_W), .IDX_W(IDX_W)
  ) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_addr(wr_sel_addr),
    .wr_idx(wr_idx), .wr_data(wr_data), .cfg_q(cfg_q), .addr_q(addr_q)
  );

  // first and last byte of the access, one bit wider to avoid wrap (R7)
  assign first_b = {1'b0, acc_addr};
  assign last_b  = first_b + (PA_W+1)'(acc_size) - (PA_W+1)'(1);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_match
    logic [PA_W-3:0] prev_reg;
    if (i == 0) begin : g_first
      assign prev_reg = '0;
    end else begin : g_rest
      assign prev_reg = addr_q[i-1];
    end
    pmp_region_match #(.PA_W(PA_W)) u_match (
      .mode(cfg_q[i][CFG_MODE_HI:CFG_MODE_LO]), .own_reg(addr_q[i]),
      .prev_reg(prev_reg), .first_b(first_b), .last_b(last_b),
      .first_in(first_vec[i]), .last_in(last_vec[i])
    );
  end

  assign hit_vec = first_vec | last_vec;

  pmp_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .req(hit_vec), .grant(grant_vec), .any(any_hit)
  );

  assign full_hit    = |(grant_vec & first_vec & last_vec);
  assign partial_hit = any_hit && !full_hit;

  always_comb begin
    sel_perm        = '0;
    sel_lock        = 1'b0;
    unused_cfg_rsvd = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      unused_cfg_rsvd ^= ^cfg_q[i][6:5];
      if (grant_vec[i]) begin
        sel_perm |= cfg_q[i][CFG_X:CFG_R];
        sel_lock |= cfg_q[i][CFG_LOCK];
      end
    end
  end

  always_comb begin
    if (!any_hit)                                allow = (acc_priv == PRIV_M);
    else if (partial_hit)                        allow = 1'b0;
    else if ((acc_priv == PRIV_M) && !sel_lock)  allow = 1'b1;
    else                                         allow = perm_ok(sel_perm, acc_type);
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PA_W        = 56
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_ENTRIES-1:0][7:0]      cfg_q,
  input logic [NUM_ENTRIES-1:0][PA_W-3:0] addr_q,
  input logic [NUM_ENTRIES-1:0]           hit_vec,
  input logic [NUM_ENTRIES-1:0]           grant_vec,
  input logic                             any_hit,
  input logic                             partial_hit,
  input logic [1:0]                       acc_priv,
  input logic                             allow
);
  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_grant_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (((grant_vec & hit_vec) == grant_vec) &&
                 ((hit_vec & (grant_vec - NUM_ENTRIES'(1))) == '0)));

  p_partial_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    partial_hit |-> !allow);

  p_default_policy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (allow == (acc_priv == PRIV_M)));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_lock
    p_locked_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][CFG_LOCK] |=> $stable(cfg_q[i]));
    p_locked_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[i][CFG_LOCK] |=> $stable(addr_q[i]));
  end
endmodule

bind pmp_checker pmp_checker_sva #(.NUM_ENTRIES(NUM_ENTRIES), .PA_W(PA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .addr_q(addr_q),
  .hit_vec(hit_vec), .grant_vec(grant_vec), .any_hit(any_hit),
  .partial_hit(partial_hit), .acc_priv(acc_priv), .allow(allow)
);

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb_top;
  localparam int N = 16;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel_addr = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [55:0] acc_addr = '0;
  logic [3:0]  acc_size = 4'd1;
  logic [1:0]  acc_type = RD;
  logic [1:0]  acc_priv = PM;
  logic        allow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pmp_checker #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_addr(wr_sel_addr),
    .wr_idx(wr_idx), .wr_data(wr_data), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_type(acc_type), .acc_priv(acc_priv),
    .allow(allow)
  );

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // register write: driven at a falling edge, taken at the next rising edge
  task automatic wr(input bit is_addr, input int idx, input logic [63:0] d);
    wr_en = 1'b1; wr_sel_addr = is_addr; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // address register holds byte address >> 2
  task automatic wr_region(input int idx, input logic [63:0] byte_addr, input logic [7:0] cfg);
    wr(1'b1, idx, byte_addr >> 2);
    wr(1'b0, idx, {56'd0, cfg});
  endtask

  // allow is combinational: sample 1 ns after driving, away from clock edges
  task automatic acc(input logic [63:0] a, input int sz, input logic [1:0] t,
                     input logic [1:0] p, input logic exp, input string tag);
    acc_addr = a[55:0]; acc_size = 4'(sz); acc_type = t; acc_priv = p;
    #1;
    checks++;
    if (allow !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h size=%0d got allow=%b expected %b", tag, a, sz, allow, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    acc(64'h0, 1, RD, PM, 1'b1, "R1 reset machine default");
    acc(64'h0, 1, RD, PS, 1'b0, "R1 reset supervisor default");
    acc(64'h1234, 4, WR, PU, 1'b0, "R9 reset user default");
  endtask

  task automatic t_napot();
    do_reset();
    // base 0x1000, two trailing ones -> 32 bytes, read only (cfg 0x19)
    wr(1'b1, 0, 64'h403);
    wr(1'b0, 0, 64'h19);
    acc(64'h1000, 1, RD, PS, 1'b1, "R2 napot base");
    acc(64'h101F, 1, RD, PS, 1'b1, "R2 napot inclusive end");
    acc(64'h1020, 1, RD, PS, 1'b0, "R2 napot past end");
    acc(64'h0FFF, 1, RD, PS, 1'b0, "R2 napot below base");
    acc(64'h101C, 4, RD, PS, 1'b1, "R7 napot full fit");
    acc(64'h101D, 4, RD, PS, 1'b0, "R7 napot straddle supervisor");
    acc(64'h101D, 4, RD, PM, 1'b0, "R7 napot straddle machine");
    acc(64'h1008, 8, WR, PS, 1'b0, "R8 napot no write bit");
    acc(64'h1008, 8, WR, PM, 1'b1, "R9 unlocked machine bypass");
  endtask

  task automatic t_tor();
    do_reset();
    // entry 0 off but supplies the lower bound; entry 1 range, write only (0x0A)
    wr_region(0, 64'h2000, 8'h00);
    wr_region(1, 64'h3000, 8'h0A);
    acc(64'h2000, 1, WR, PS, 1'b1, "R5 off entry still bounds range");
    acc(64'h2FFC, 4, WR, PS, 1'b1, "R3 range top word");
    acc(64'h3000, 1, WR, PS, 1'b0, "R3 range upper exclusive");
    acc(64'h1FFF, 1, WR, PS, 1'b0, "R5 off entry never matches");
    acc(64'h2800, 2, RD, PU, 1'b0, "R8 range no read bit user");
    // entry 0 in range mode starts at zero, execute only (0x0C)
    do_reset();
    wr_region(0, 64'h100, 8'h0C);
    acc(64'h0, 1, EX, PS, 1'b1, "R3 entry0 lower bound zero");
    acc(64'hFF, 1, EX, PS, 1'b1, "R3 entry0 last byte");
    acc(64'h100, 1, EX, PS, 1'b0, "R3 entry0 top");
    acc(64'h40, 1, RD, PS, 1'b0, "R8 exec-only read denied");
    // empty range: upper bound below lower bound
    wr_region(1, 64'h80, 8'h0F);
    acc(64'h100, 1, RD, PM, 1'b1, "R3 empty range machine default");
    acc(64'h100, 1, RD, PS, 1'b0, "R3 empty range supervisor default");
  endtask

  task automatic t_na4();
    do_reset();
    wr_region(3, 64'h500, 8'h11);
    acc(64'h503, 1, RD, PS, 1'b1, "R4 word last byte");
    acc(64'h504, 1, RD, PS, 1'b0, "R4 word past end");
    acc(64'h502, 2, RD, PS, 1'b1, "R4 halfword inside");
    acc(64'h503, 2, RD, PS, 1'b0, "R7 word straddle");
  endtask

  task automatic t_priority();
    do_reset();
    // entry 2: 4 KiB block at 0x4000 read/write (0x1B); entry 5: word at 0x4100 read only
    wr(1'b1, 2, 64'h11FF);
    wr(1'b0, 2, 64'h1B);
    wr_region(5, 64'h4100, 8'h11);
    acc(64'h4100, 4, WR, PS, 1'b1, "R6 lower index block wins");
    wr_region(1, 64'h4100, 8'h11);
    acc(64'h4100, 4, WR, PS, 1'b0, "R6 new lowest entry wins");
    acc(64'h4200, 4, WR, PS, 1'b1, "R6 outside word uses block");
    acc(64'h4102, 4, RD, PS, 1'b0, "R7 partial on deciding entry");
    wr(1'b0, 1, 64'h00);
    acc(64'h4100, 4, WR, PS, 1'b1, "R5 entry switched off ignored");
  endtask

  task automatic t_lock();
    do_reset();
    wr_region(0, 64'h600, 8'h10);
    acc(64'h600, 1, RD, PM, 1'b1, "R9 unlocked no-perm machine allowed");
    acc(64'h600, 1, RD, PS, 1'b0, "R8 no-perm supervisor denied");
    wr(1'b0, 0, 64'h90);
    acc(64'h600, 1, RD, PM, 1'b0, "R9 locked entry binds machine");
    wr(1'b0, 0, 64'h17);
    acc(64'h600, 1, RD, PM, 1'b0, "R10 locked cfg write ignored");
    wr(1'b1, 0, 64'h700 >> 2);
    acc(64'h700, 1, RD, PM, 1'b1, "R10 locked addr write ignored");
    acc(64'h600, 1, RD, PM, 1'b0, "R10 locked region unchanged");
    // entry 2 locked range, read only; entry 1 becomes protected
    wr(1'b1, 1, 64'h800 >> 2);
    wr_region(2, 64'h900, 8'h89);
    acc(64'h800, 1, RD, PM, 1'b1, "R9 locked range read");
    acc(64'h850, 1, WR, PM, 1'b0, "R9 locked range write denied");
    wr(1'b1, 1, 64'h880 >> 2);
    acc(64'h850, 1, WR, PM, 1'b0, "R10 bound below locked range kept");
    wr_region(3, 64'hA00, 8'h11);
    acc(64'hA00, 1, RD, PS, 1'b1, "R10 unlocked entry still writable");
  endtask

  task automatic t_wide_write();
    do_reset();
    wr(1'b1, 0, 64'hFFC0_0000_0000_0000 | (64'hB00 >> 2));
    wr(1'b0, 0, 64'h11);
    acc(64'hB00, 1, RD, PS, 1'b1, "R11 high write bits discarded");
    acc(64'hB04, 1, RD, PS, 1'b0, "R11 region is one word");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_napot();
    t_tor();
    t_na4();
    t_priority();
    t_lock();
    t_wide_write();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule